// File: doc/BRIEF.md
# Precision Time Counter with Rate Correction

This block keeps a nanosecond time-of-day count for packet timestamping. On every enabled reference clock it adds a small programmable step to the count. The step is normally the base increment. If a correction interval is programmed, then once in every (interval + 1) counted clocks the block adds a separate trim increment in its place. Choosing the trim step and the interval lets software speed the clock up or slow it down by a fine amount without changing the reference frequency.

Software reaches the block through a word-addressed write port and a registered read port. Through these it can enable counting, zero the count, load an arbitrary time and take a snapshot. A read of the time address returns the snapshot, not the running value. The count can be made to roll over at a programmable period. Each rollover raises a one-cycle event pulse. A second copy of that pulse is gated for compare channels, and those channels also share the live time output.

Register map (word addresses): 0 control, 1 time, 2 rollover period, 3 correction interval, 4 increments.

Top module: `ptc_time_core`

## Requirements
- R1: After a synchronous reset the live time, the snapshot and both event outputs are 0, and all control bits are clear.
- R2: While control bit 0 is set, the live time grows each clock by the base increment held in bits [6:0] of address 4. While bit 0 is clear, the time holds its value.
- R3: With a nonzero correction interval P at address 3, every (P+1)th counted clock adds the trim increment from bits [14:8] of address 4 instead of the base increment. With P = 0, the trim increment is never used.
- R4: Any write to address 3 restarts the correction cycle count, so that the next trim step falls on the (P+1)th counted clock after the write.
- R5: A control write with bit 11 set copies the live time from before that edge into the snapshot. Reads of address 1 return only the snapshot. Bit 11 is not stored and reads back as 0.
- R6: A write to address 1 sets the live time to the written value on that edge, with no increment added.
- R7: A control write with bit 9 set forces the live time to zero on that edge, with no increment added. It takes priority over a load, and bit 9 is not stored.
- R8: When control bits 5 and 4 are both set and the period at address 2 is nonzero, a step whose sum reaches or passes the period stores (sum minus period), and evt_o is high in the cycle that shows this new value.
- R9: If either bit 5 or bit 4 is clear, the count passes the period without rolling over, and evt_o stays low.
- R10: cmp_evt_o pulses together with evt_o when control bit 7 is set and stays low when bit 7 is clear.
- R11: A read of address 4 returns the increment fields in bits [14:8] and [6:0] and zeros elsewhere. Read data appears one clock after the read address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | CNT_W | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | CNT_W | Registered read data |
| time_o | output | CNT_W | Live time value shared with compare channels |
| evt_o | output | 1 | Rollover event pulse |
| cmp_evt_o | output | 1 | Rollover pulse gated for compare channels |

## Verification
The hardest case to reach from the ports is the correction cycle count being restarted partway through an interval. That count is never visible, so its effect has to be read from the time value alone. The stimulus counts two clocks into a three-cycle interval and then rewrites the interval at address 3. The time is checked at the point where a stale count would already have applied the trim step, and again where a restarted count applies it. Rollover is reached by loading a value one step below the period, so that the roll falls on a known edge. One load lands exactly on the period and another lands past it.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
  // register word addresses
  localparam int A_CTRL   = 0;
  localparam int A_TIME   = 1;
  localparam int A_PERIOD = 2;
  localparam int A_CORR   = 3;
  localparam int A_INCR   = 4;
  // control bit positions
  localparam int B_EN      = 0;
  localparam int B_WRAP_LO = 4;
  localparam int B_WRAP_HI = 5;
  localparam int B_PIN     = 7;
  localparam int B_RESTART = 9;
  localparam int B_CAPTURE = 11;
  // trim increment field position in the increment register
  localparam int TRIM_LSB  = 8;
endpackage

// File: rtl/ptc_regs.sv
module ptc_regs
  import ptc_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 3,
  parameter int INC_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [CNT_W-1:0]  snap_i,
  output logic [CNT_W-1:0]  rd_data,
  output logic              en_o,
  output logic              wrap_en_o,
  output logic              pin_o,
  output logic [CNT_W-1:0]  period_o,
  output logic [CNT_W-1:0]  interval_o,
  output logic [INC_W-1:0]  base_inc_o,
  output logic [INC_W-1:0]  trim_inc_o,
  output logic              restart_o,
  output logic              load_o,
  output logic              capture_o,
  output logic              interval_wr_o
);
  logic wr_ctrl;
  logic en_q, wlo_q, whi_q, pin_q;
  logic [CNT_W-1:0] period_q, interval_q;
  logic [INC_W-1:0] base_q, trim_q;

  assign wr_ctrl       = wr_en && (wr_addr == ADDR_W'(A_CTRL));
  assign restart_o     = wr_ctrl && wr_data[B_RESTART];
  assign capture_o     = wr_ctrl && wr_data[B_CAPTURE];
  assign load_o        = wr_en && (wr_addr == ADDR_W'(A_TIME));
  assign interval_wr_o = wr_en && (wr_addr == ADDR_W'(A_CORR));

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0; wlo_q <= 1'b0; whi_q <= 1'b0; pin_q <= 1'b0;
      period_q <= '0; interval_q <= '0; base_q <= '0; trim_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_W'(A_CTRL): begin
          en_q  <= wr_data[B_EN];
          wlo_q <= wr_data[B_WRAP_LO];
          whi_q <= wr_data[B_WRAP_HI];
          pin_q <= wr_data[B_PIN];
        end
        ADDR_W'(A_PERIOD): period_q   <= wr_data;
        ADDR_W'(A_CORR):   interval_q <= wr_data;
        ADDR_W'(A_INCR): begin
          base_q <= wr_data[INC_W-1:0];
          trim_q <= wr_data[TRIM_LSB +: INC_W];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      rd_data <= '0;
      case (rd_addr)
        ADDR_W'(A_CTRL): begin
          rd_data[B_EN]      <= en_q;
          rd_data[B_WRAP_LO] <= wlo_q;
          rd_data[B_WRAP_HI] <= whi_q;
          rd_data[B_PIN]     <= pin_q;
        end
        ADDR_W'(A_TIME):   rd_data <= snap_i;
        ADDR_W'(A_PERIOD): rd_data <= period_q;
        ADDR_W'(A_CORR):   rd_data <= interval_q;
        ADDR_W'(A_INCR): begin
          rd_data[INC_W-1:0]          <= base_q;
          rd_data[TRIM_LSB +: INC_W]  <= trim_q;
        end
        default: ;
      endcase
    end
  end

  assign en_o       = en_q;
  assign wrap_en_o  = wlo_q && whi_q;
  assign pin_o      = pin_q;
  assign period_o   = period_q;
  assign interval_o = interval_q;
  assign base_inc_o = base_q;
  assign trim_inc_o = trim_q;
endmodule

// File: rtl/ptc_rate_sel.sv
module ptc_rate_sel #(
  parameter int CNT_W = 32,
  parameter int INC_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_i,
  input  logic             interval_wr_i,
  input  logic [CNT_W-1:0] interval_i,
  input  logic [INC_W-1:0] base_inc_i,
  input  logic [INC_W-1:0] trim_inc_i,
  output logic [INC_W-1:0] inc_o
);
  logic [CNT_W-1:0] phase_q;
  logic trim_now;

  assign trim_now = (interval_i != '0) && (phase_q == interval_i);
  assign inc_o    = trim_now ? trim_inc_i : base_inc_i;

  always_ff @(posedge clk) begin
    if (rst || interval_wr_i) phase_q <= '0;
    else if (step_i && (interval_i != '0))
      phase_q <= trim_now ? '0 : phase_q + 1'b1;
  end
endmodule

// File: rtl/ptc_counter.sv
module ptc_counter #(
  parameter int CNT_W = 32,
  parameter int INC_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_i,
  input  logic [INC_W-1:0] inc_i,
  input  logic             restart_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             capture_i,
  input  logic             wrap_en_i,
  input  logic             pin_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] time_o,
  output logic [CNT_W-1:0] snap_o,
  output logic             evt_o,
  output logic             cmp_o
);
  localparam int SUM_W = CNT_W + 1;
  logic [SUM_W-1:0] sum, per_ext;
  logic roll;

  assign sum     = {1'b0, time_o} + SUM_W'(inc_i);
  assign per_ext = {1'b0, period_i};
  assign roll    = wrap_en_i && (period_i != '0) && (sum >= per_ext);

  always_ff @(posedge clk) begin
    if (rst) begin
      time_o <= '0; snap_o <= '0; evt_o <= 1'b0; cmp_o <= 1'b0;
    end else begin
      evt_o <= 1'b0;
      cmp_o <= 1'b0;
      if (capture_i) snap_o <= time_o;
      if (restart_i)   time_o <= '0;
      else if (load_i) time_o <= load_val_i;
      else if (step_i) begin
        if (roll) begin
          time_o <= CNT_W'(sum - per_ext);
          evt_o  <= 1'b1;
          cmp_o  <= pin_i;
        end else begin
          time_o <= sum[CNT_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/ptc_time_core.sv
module ptc_time_core #(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 3,
  parameter int INC_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  output logic [CNT_W-1:0]  time_o,
  output logic              evt_o,
  output logic              cmp_evt_o
);
  logic cnt_en, wrap_en, pin, restart, load, capture, interval_wr, step;
  logic [CNT_W-1:0] period, interval, cap_val;
  logic [INC_W-1:0] base_inc, trim_inc, inc;

  ptc_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .INC_W(INC_W)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .snap_i(cap_val), .rd_data(rd_data),
    .en_o(cnt_en), .wrap_en_o(wrap_en), .pin_o(pin), .period_o(period),
    .interval_o(interval), .base_inc_o(base_inc), .trim_inc_o(trim_inc),
    .restart_o(restart), .load_o(load), .capture_o(capture),
    .interval_wr_o(interval_wr)
  );

  assign step = cnt_en && !restart && !load;

  ptc_rate_sel #(.CNT_W(CNT_W), .INC_W(INC_W)) rate_i (
    .clk(clk), .rst(rst), .step_i(step), .interval_wr_i(interval_wr),
    .interval_i(interval), .base_inc_i(base_inc), .trim_inc_i(trim_inc),
    .inc_o(inc)
  );

  ptc_counter #(.CNT_W(CNT_W), .INC_W(INC_W)) cnt_i (
    .clk(clk), .rst(rst), .step_i(step), .inc_i(inc), .restart_i(restart),
    .load_i(load), .load_val_i(wr_data), .capture_i(capture),
    .wrap_en_i(wrap_en), .pin_i(pin), .period_i(period),
    .time_o(time_o), .snap_o(cap_val), .evt_o(evt_o), .cmp_o(cmp_evt_o)
  );
endmodule

// File: rtl/ptc_time_core_chk.sv
module ptc_time_core_chk
  import ptc_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [CNT_W-1:0]  wr_data,
  input logic [CNT_W-1:0]  time_o,
  input logic              evt_o,
  input logic              cmp_evt_o,
  input logic              cnt_en,
  input logic [CNT_W-1:0]  cap_val
);
  logic wr_time, wr_ctrl;
  assign wr_time = wr_en && (wr_addr == ADDR_W'(A_TIME));
  assign wr_ctrl = wr_en && (wr_addr == ADDR_W'(A_CTRL));

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (time_o == '0 && !evt_o && !cmp_evt_o));

  // R2
  hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!cnt_en && !wr_time && !wr_ctrl) |=> $stable(time_o));

  // R5
  snap_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_ctrl && wr_data[B_CAPTURE]) |=> $stable(cap_val));

  // R6
  load_value_chk: assert property (@(posedge clk) disable iff (rst)
    wr_time |=> (time_o == $past(wr_data)));

  // R7
  restart_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && wr_data[B_RESTART]) |=> (time_o == '0));

  // R8
  evt_needs_count_chk: assert property (@(posedge clk) disable iff (rst)
    evt_o |-> $past(cnt_en));

  // R10
  cmp_follows_evt_chk: assert property (@(posedge clk) disable iff (rst)
    cmp_evt_o |-> evt_o);
endmodule

bind ptc_time_core ptc_time_core_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .time_o(time_o), .evt_o(evt_o), .cmp_evt_o(cmp_evt_o),
  .cnt_en(cnt_en), .cap_val(cap_val)
);

// File: tb/ptc_time_core_tb_top.sv
module ptc_time_core_tb_top;
  localparam int CNT_W = 32;
  localparam int ADDR_W = 3;
  localparam int AC = 0, AT = 1, AP = 2, AK = 3, AI = 4;
  // base inc, trim inc, interval, counted clocks, expected time
  localparam int unsigned VEC [6][5] = '{
    '{8, 0, 0, 10, 80},
    '{8, 9, 3, 10, 82},
    '{8, 7, 4, 10, 78},
    '{5, 6, 0, 7, 35},
    '{1, 3, 1, 9, 17},
    '{10, 10, 2, 6, 60}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [CNT_W-1:0] wr_data = '0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [CNT_W-1:0] rd_data, time_o;
  logic evt_o, cmp_evt_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ptc_time_core #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .time_o(time_o), .evt_o(evt_o),
    .cmp_evt_o(cmp_evt_o)
  );

  task automatic chk(input string req, input logic [CNT_W-1:0] got, input logic [CNT_W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [CNT_W-1:0] d);
    wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [CNT_W-1:0] d);
    rd_addr = ADDR_W'(a);
    @(negedge clk);
    d = rd_data;
  endtask

  initial begin
    logic [CNT_W-1:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(AT, v);
    chk("R1 snapshot", v, 0);
    chk("R1 time", time_o, 0);
    chk("R1 evt", {31'b0, evt_o}, 0);
    rd(AC, v);
    chk("R1 control", v, 0);

    // R2 R3 table of rates
    for (int i = 0; i < 6; i++) begin
      wr(AC, 32'h200);
      wr(AI, (VEC[i][1] << 8) | VEC[i][0]);
      wr(AK, VEC[i][2]);
      wr(AC, 32'h1);
      repeat (VEC[i][3] - 1) @(negedge clk);
      wr(AC, 32'h0);
      wr(AC, 32'h800);
      rd(AT, v);
      chk("R2/R3 rate vector snapshot", v, VEC[i][4]);
      chk("R2 held time", time_o, VEC[i][4]);
    end

    // R11 increment readback
    wr(AI, 32'hFFFF_FFFF);
    rd(AI, v);
    chk("R11 incr readback", v, 32'h7F7F);

    // R5 snapshot holds while counting
    wr(AI, 10);
    wr(AC, 32'h1);
    repeat (4) @(negedge clk);
    rd(AT, v);
    chk("R5 snapshot unchanged", v, 60);
    chk("R5 live time moved", {31'b0, time_o != 60}, 1);
    rd(AC, v);
    chk("R5 capture bit not stored", v, 1);

    // R6 load, R7 restart
    wr(AI, 8);
    wr(AK, 0);
    wr(AT, 1000);
    chk("R6 load value", time_o, 1000);
    @(negedge clk);
    chk("R6 counting after load", time_o, 1008);
    wr(AC, 32'h201);
    chk("R7 restart to zero", time_o, 0);
    @(negedge clk);
    chk("R7 counting after restart", time_o, 8);

    // R4 interval rewrite restarts the cycle count
    wr(AC, 32'h200);
    wr(AI, (20 << 8) | 8);
    wr(AK, 3);
    wr(AC, 32'h1);
    @(negedge clk);
    @(negedge clk);
    wr(AK, 3);
    chk("R4 at rewrite", time_o, 24);
    repeat (3) @(negedge clk);
    chk("R4 no early trim", time_o, 48);
    @(negedge clk);
    chk("R4 trim after restart", time_o, 68);

    // R8 R10 rollover
    wr(AC, 32'h200);
    wr(AP, 100);
    wr(AI, 8);
    wr(AK, 0);
    wr(AC, 32'hB1);
    wr(AT, 92);
    chk("R8 loaded", time_o, 92);
    @(negedge clk);
    chk("R8 exact roll", time_o, 0);
    chk("R8 evt", {31'b0, evt_o}, 1);
    chk("R10 cmp on", {31'b0, cmp_evt_o}, 1);
    @(negedge clk);
    chk("R8 after roll", time_o, 8);
    chk("R8 evt single", {31'b0, evt_o}, 0);
    wr(AC, 32'h31);
    wr(AT, 96);
    @(negedge clk);
    chk("R8 roll remainder", time_o, 4);
    chk("R10 cmp off evt", {31'b0, evt_o}, 1);
    chk("R10 cmp off", {31'b0, cmp_evt_o}, 0);
    // R9 one wrap bit only
    wr(AC, 32'h11);
    wr(AT, 96);
    @(negedge clk);
    chk("R9 no roll", time_o, 104);
    chk("R9 no evt", {31'b0, evt_o}, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog got 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule